// File: doc/BRIEF.md
# Comma Sync State Machine

This block sits in one receive lane directly after the 10-bit deserializer. The deserializer's word boundary is arbitrary, so the block keeps the previous word and looks for a comma code group at each of the ten possible bit offsets, including those that straddle two words. When it finds one, it moves its word boundary to that offset. From then on it emits 10-bit code groups re-framed to that boundary.

On top of the aligner, a synchronization state machine decides whether the lane can be trusted. It declares the lane in sync after four commas at a stable boundary. Once in sync, it stops the boundary from moving. It drops sync when the external decoder keeps reporting invalid code groups or disparity errors, or when the signal-present input goes low. The decoder is outside this block. It decodes `aligned_word` and returns its verdict on `code_err` in the same cycle.

Top module: `lane_comma_sync`

## Requirements
- R1: Bit 9 of each input word is the earliest received bit. A comma is any 10-bit group whose first seven bits are 0011111 or 1100000. This covers K28.1, K28.5 and K28.7 in both running disparities. Such a group is found at every offset 0 to 9, counted in bits from the start of the previous word, including groups that span two words.
- R2: `aligned_word` is registered and holds the 10 bits starting at the current boundary offset. `comma_seen` is high in the same cycle exactly when that word is a comma.
- R3: `in_sync` rises after four commas at the same boundary with no invalid code group in between. Any number of valid non-comma groups may separate the commas.
- R4: While out of sync, an invalid code group (`code_err` high) clears the comma count.
- R5: While out of sync, a comma at an offset other than the current boundary moves the boundary to that offset, and the comma count restarts at one. If several offsets match, the lowest offset wins.
- R6: While in sync, the boundary does not move. Commas at other offsets have no effect and do not raise `comma_seen`.
- R7: While in sync, every invalid code group adds one to an error level. After an error, four consecutive valid groups remove one level. Reaching four levels drops sync.
- R8: `sig_ok` low drops sync at the next clock edge and clears the comma count.
- R9: Reset (`rst_n` low, asynchronous) clears `aligned_word`, `comma_seen` and `in_sync`, and sets the boundary to offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_word | input | 10 | Raw deserialized word, bit 9 received first |
| sig_ok | input | 1 | Signal present; low means loss of signal |
| code_err | input | 1 | Decoder verdict on the current `aligned_word`: invalid code or disparity error |
| aligned_word | output | 10 | Code group re-framed to the locked boundary |
| comma_seen | output | 1 | `aligned_word` is a comma |
| in_sync | output | 1 | Lane synchronized |

## Verification
On every cycle, the assertions check these properties:
- The boundary stays frozen while the lane is in sync.
- A boundary move happens only while the lane is hunting.
- Sync rises only right after a comma.
- Loss of signal or a fourth error level forces sync low.
- Every flagged comma really carries a comma pattern.

Only the bench scenarios can show the rest. These are: sync is reached after exactly four commas at every offset and for every comma kind; the count restarts after a bit slip; it clears on an acquisition error; commas at a foreign offset are ignored while in sync; and the forgiveness run lets a lane survive errors that would otherwise drop it.

// File: rtl/lane_sync_pkg.sv
package lane_sync_pkg;

  localparam int SYM_W = 10;
  localparam int OFF_W = $clog2(SYM_W);
  localparam int WIN_W = 2 * SYM_W - 1;
  localparam int TAG_W = 7;

  localparam logic [TAG_W-1:0] TAG_LOW  = 7'b0011111;
  localparam logic [TAG_W-1:0] TAG_HIGH = 7'b1100000;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [WIN_W-1:0] win_t;
  typedef logic [OFF_W-1:0] off_t;

  typedef enum logic {ST_HUNT, ST_LOCKED} lock_st_e;

  // comma test on the first seven received bits of a group
  function automatic logic is_comma(sym_t s);
    return (s[SYM_W-1 -: TAG_W] == TAG_LOW) || (s[SYM_W-1 -: TAG_W] == TAG_HIGH);
  endfunction

  // group starting k bits after the first bit of the previous word
  function automatic sym_t slice_at(win_t w, off_t k);
    win_t t;
    t = w >> ((SYM_W - 1) - int'(k));
    return t[SYM_W-1:0];
  endfunction

  // lowest set index of a per-offset match vector
  function automatic off_t lowest_set(sym_t v);
    off_t r;
    r = '0;
    for (int i = SYM_W - 1; i >= 0; i--) begin
      if (v[i]) r = off_t'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/comma_scanner.sv
module comma_scanner
  import lane_sync_pkg::*;
(
  input  win_t win,
  output sym_t match,
  output logic hit,
  output off_t hit_off
);

  for (genvar k = 0; k < SYM_W; k++) begin : g_off
    assign match[k] = is_comma(slice_at(win, off_t'(k)));
  end

  assign hit     = |match;
  assign hit_off = lowest_set(match);

endmodule

// File: rtl/boundary_tracker.sv
module boundary_tracker
  import lane_sync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  win_t win,
  input  sym_t match,
  input  logic hit,
  input  off_t hit_off,
  input  logic locked,
  output off_t boundary,
  output sym_t word_q,
  output logic comma_q,
  output logic moved_q
);

  off_t eff;
  logic relocate;

  always_comb begin
    relocate = !locked && hit && (hit_off != boundary);
    eff      = relocate ? hit_off : boundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boundary <= '0;
      word_q   <= '0;
      comma_q  <= 1'b0;
      moved_q  <= 1'b0;
    end else begin
      boundary <= eff;
      word_q   <= slice_at(win, eff);
      comma_q  <= match[eff];
      moved_q  <= relocate;
    end
  end

endmodule

// File: rtl/sync_fsm.sv
module sync_fsm
  import lane_sync_pkg::*;
#(
  parameter int COMMAS_TO_LOCK  = 4,
  parameter int ERRS_TO_UNLOCK  = 4,
  parameter int GOOD_TO_FORGIVE = 4,
  localparam int EW = $clog2(ERRS_TO_UNLOCK + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig_ok,
  input  logic          code_err,
  input  logic          comma,
  input  logic          moved,
  output logic          locked,
  output logic [EW-1:0] err_level
);

  localparam int CW = $clog2(COMMAS_TO_LOCK + 1);
  localparam int GW = $clog2(GOOD_TO_FORGIVE + 1);

  lock_st_e      st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [EW-1:0] err, err_n;
  logic [GW-1:0] good, good_n;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    err_n  = err;
    good_n = good;
    if (!sig_ok) begin
      st_n   = ST_HUNT;
      cnt_n  = '0;
      err_n  = '0;
      good_n = '0;
    end else if (st == ST_HUNT) begin
      if (code_err) begin
        cnt_n = '0;
      end else if (moved) begin
        cnt_n = CW'(1);
      end else if (comma) begin
        if (cnt == CW'(COMMAS_TO_LOCK - 1)) begin
          st_n   = ST_LOCKED;
          cnt_n  = '0;
          err_n  = '0;
          good_n = '0;
        end else begin
          cnt_n = cnt + CW'(1);
        end
      end
    end else begin
      if (code_err) begin
        good_n = '0;
        if (err == EW'(ERRS_TO_UNLOCK - 1)) begin
          st_n  = ST_HUNT;
          err_n = '0;
          cnt_n = '0;
        end else begin
          err_n = err + EW'(1);
        end
      end else if (err != '0) begin
        if (good == GW'(GOOD_TO_FORGIVE - 1)) begin
          good_n = '0;
          err_n  = err - EW'(1);
        end else begin
          good_n = good + GW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_HUNT;
      cnt  <= '0;
      err  <= '0;
      good <= '0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      err  <= err_n;
      good <= good_n;
    end
  end

  assign locked    = (st == ST_LOCKED);
  assign err_level = err;

endmodule

// File: rtl/lane_comma_sync.sv
module lane_comma_sync
  import lane_sync_pkg::*;
#(
  parameter int COMMAS_TO_LOCK  = 4,
  parameter int ERRS_TO_UNLOCK  = 4,
  parameter int GOOD_TO_FORGIVE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] rx_word,
  input  logic             sig_ok,
  input  logic             code_err,
  output logic [SYM_W-1:0] aligned_word,
  output logic             comma_seen,
  output logic             in_sync
);

  localparam int EW = $clog2(ERRS_TO_UNLOCK + 1);

  sym_t          prev_q;
  win_t          win;
  sym_t          match;
  logic          hit;
  off_t          hit_off;
  off_t          boundary;
  logic          moved;
  logic [EW-1:0] err_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= rx_word;
  end

  assign win = {prev_q, rx_word[SYM_W-1:1]};

  comma_scanner u_scan (
    .win     (win),
    .match   (match),
    .hit     (hit),
    .hit_off (hit_off)
  );

  boundary_tracker u_bound (
    .clk      (clk),
    .rst_n    (rst_n),
    .win      (win),
    .match    (match),
    .hit      (hit),
    .hit_off  (hit_off),
    .locked   (in_sync),
    .boundary (boundary),
    .word_q   (aligned_word),
    .comma_q  (comma_seen),
    .moved_q  (moved)
  );

  sync_fsm #(
    .COMMAS_TO_LOCK  (COMMAS_TO_LOCK),
    .ERRS_TO_UNLOCK  (ERRS_TO_UNLOCK),
    .GOOD_TO_FORGIVE (GOOD_TO_FORGIVE)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sig_ok    (sig_ok),
    .code_err  (code_err),
    .comma     (comma_seen),
    .moved     (moved),
    .locked    (in_sync),
    .err_level (err_level)
  );

endmodule

// File: rtl/lane_comma_sync_chk.sv
module lane_comma_sync_chk
  import lane_sync_pkg::*;
#(
  parameter int ERRS_TO_UNLOCK = 4,
  localparam int EW = $clog2(ERRS_TO_UNLOCK + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sig_ok,
  input logic          code_err,
  input sym_t          aligned_word,
  input logic          comma_seen,
  input logic          in_sync,
  input off_t          boundary,
  input logic          moved,
  input logic [EW-1:0] err_level
);

  AST_BOUNDARY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && $past(in_sync)) |-> $stable(boundary)); // R6

  AST_MOVE_ONLY_HUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    moved |-> !$past(in_sync)); // R5

  AST_SYNC_AFTER_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync) |-> $past(comma_seen)); // R3

  AST_SIG_LOSS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !sig_ok |=> !in_sync); // R8

  AST_ERR_LIMIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sync && code_err && err_level == EW'(ERRS_TO_UNLOCK - 1)) |=> !in_sync); // R7

  AST_FLAGGED_IS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
    comma_seen |-> is_comma(aligned_word)); // R2

endmodule

bind lane_comma_sync lane_comma_sync_chk #(.ERRS_TO_UNLOCK(ERRS_TO_UNLOCK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sig_ok       (sig_ok),
  .code_err     (code_err),
  .aligned_word (aligned_word),
  .comma_seen   (comma_seen),
  .in_sync      (in_sync),
  .boundary     (boundary),
  .moved        (moved),
  .err_level    (err_level)
);

// File: tb/lane_comma_sync_test.sv
module lane_comma_sync_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] rx_word;
  logic       sig_ok;
  logic       code_err;
  logic [9:0] aligned_word;
  logic       comma_seen;
  logic       in_sync;

  always #5 clk = ~clk;

  lane_comma_sync uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_word      (rx_word),
    .sig_ok       (sig_ok),
    .code_err     (code_err),
    .aligned_word (aligned_word),
    .comma_seen   (comma_seen),
    .in_sync      (in_sync)
  );

  // alternating data group and a distinctive marker, neither forms a comma at any offset
  localparam logic [9:0] FILL = 10'b1010101010;
  localparam logic [9:0] MARK = 10'b1001110100;

  // vector: {skew[7:4], comma kind[3:2], extra gap groups[1:0]}
  localparam logic [7:0] VECS [0:5] = '{8'h01, 8'h34, 8'h7A, 8'h93, 8'h55, 8'h18};

  int   checks = 0;
  int   fails  = 0;
  int   comma_pulses;
  bit   watch_seen;
  logic [9:0] watch;
  bit   err_now;
  bit   sig_now;
  bit   pol;
  bit   bitq [$];

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [9:0] comma_code(int kind, bit p);
    case (kind)
      0:       return p ? 10'b1100000101 : 10'b0011111010;
      1:       return p ? 10'b1100000110 : 10'b0011111001;
      default: return p ? 10'b1100000111 : 10'b0011111000;
    endcase
  endfunction

  task drive_word(logic [9:0] w);
    rx_word  = w;
    code_err = err_now;
    sig_ok   = sig_now;
    @(posedge clk);
    @(negedge clk);
    if (comma_seen) comma_pulses++;
    if (aligned_word == watch) watch_seen = 1'b1;
  endtask

  task push_sym(logic [9:0] s);
    logic [9:0] w;
    for (int b = 9; b >= 0; b--) bitq.push_back(s[b]);
    while (bitq.size() >= 10) begin
      for (int b = 9; b >= 0; b--) w[b] = bitq.pop_front();
      drive_word(w);
    end
  endtask

  task push_alt(int n);
    for (int i = 0; i < n; i++) bitq.push_back(i % 2 == 0);
  endtask

  task push_comma(int kind);
    push_sym(comma_code(kind, pol));
    pol = ~pol;
  endtask

  task do_reset();
    rst_n = 1'b0;
    rx_word = '0; code_err = 1'b0; sig_ok = 1'b1;
    err_now = 1'b0; sig_now = 1'b1; pol = 1'b0;
    bitq.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    comma_pulses = 0;
    watch_seen = 1'b0;
    watch = 10'h3FF;
  endtask

  task sync_at(int skew);
    do_reset();
    push_alt(skew);
    push_sym(FILL); push_sym(FILL);
    for (int c = 0; c < 4; c++) begin push_comma(0); push_sym(FILL); end
    push_sym(FILL); push_sym(FILL);
  endtask

  task marker_check(string req);
    watch = MARK;
    watch_seen = 1'b0;
    push_sym(MARK); push_sym(FILL); push_sym(FILL);
    check(watch_seen, req, watch_seen, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R9: reset state
    check(in_sync == 1'b0, "R9 in_sync", in_sync, 0);
    check(comma_seen == 1'b0, "R9 comma_seen", comma_seen, 0);
    check(aligned_word == 10'd0, "R9 aligned_word", aligned_word, 0);

    // table walk: every skew, comma kind and gap reaches sync on the fourth comma
    for (int v = 0; v < 6; v++) begin
      int skew, kind, gap;
      skew = int'(VECS[v][7:4]);
      kind = int'(VECS[v][3:2]);
      gap  = int'(VECS[v][1:0]);
      do_reset();
      push_alt(skew);
      push_sym(FILL); push_sym(FILL);
      for (int c = 0; c < 3; c++) begin
        push_comma(kind);
        for (int g = 0; g < gap; g++) push_sym(FILL);
      end
      push_sym(FILL); push_sym(FILL);
      check(in_sync == 1'b0, "R3 three commas", in_sync, 0);
      push_comma(kind);
      push_sym(FILL); push_sym(FILL);
      check(in_sync == 1'b1, "R3 fourth comma", in_sync, 1);
      check(comma_pulses == 4, "R1 commas found at offset", comma_pulses, 4);
      marker_check("R2 aligned word");
    end

    // R4: acquisition error clears the count
    do_reset();
    push_alt(2);
    push_sym(FILL); push_sym(FILL);
    push_comma(0); push_sym(FILL); push_comma(0); push_sym(FILL);
    err_now = 1'b1; push_sym(FILL); err_now = 1'b0;
    push_comma(0); push_sym(FILL); push_comma(0); push_sym(FILL);
    push_sym(FILL); push_sym(FILL);
    check(in_sync == 1'b0, "R4 count cleared", in_sync, 0);
    push_comma(0); push_sym(FILL); push_comma(0); push_sym(FILL);
    push_sym(FILL); push_sym(FILL);
    check(in_sync == 1'b1, "R4 four after clear", in_sync, 1);

    // R5: bit slip while hunting moves the boundary and restarts the count
    do_reset();
    push_alt(3);
    push_sym(FILL); push_sym(FILL);
    push_comma(1); push_sym(FILL); push_comma(1); push_sym(FILL);
    push_alt(4);
    for (int c = 0; c < 3; c++) begin push_comma(1); push_sym(FILL); end
    push_sym(FILL); push_sym(FILL);
    check(in_sync == 1'b0, "R5 count restarted", in_sync, 0);
    push_comma(1); push_sym(FILL); push_sym(FILL);
    check(in_sync == 1'b1, "R5 sync at new offset", in_sync, 1);
    marker_check("R5 new boundary used");

    // R6: commas at a foreign offset are ignored while in sync
    sync_at(3);
    push_alt(4);
    comma_pulses = 0;
    for (int c = 0; c < 4; c++) begin push_comma(0); push_sym(FILL); end
    check(comma_pulses == 0, "R6 foreign commas unflagged", comma_pulses, 0);
    check(in_sync == 1'b1, "R6 sync kept", in_sync, 1);

    // R7: four unforgiven errors drop sync
    sync_at(6);
    for (int e = 0; e < 3; e++) begin
      err_now = 1'b1; push_sym(FILL); err_now = 1'b0; push_sym(FILL);
    end
    check(in_sync == 1'b1, "R7 three errors", in_sync, 1);
    err_now = 1'b1; push_sym(FILL); err_now = 1'b0;
    check(in_sync == 1'b0, "R7 fourth error", in_sync, 0);

    // R7: a run of four valid groups forgives one error
    sync_at(8);
    err_now = 1'b1;
    for (int e = 0; e < 3; e++) push_sym(FILL);
    err_now = 1'b0;
    for (int g = 0; g < 4; g++) push_sym(FILL);
    err_now = 1'b1; push_sym(FILL); err_now = 1'b0;
    check(in_sync == 1'b1, "R7 forgiven", in_sync, 1);
    err_now = 1'b1; push_sym(FILL); err_now = 1'b0;
    check(in_sync == 1'b0, "R7 limit after forgive", in_sync, 0);

    // R8: loss of signal
    sync_at(4);
    sig_now = 1'b0; push_sym(FILL); sig_now = 1'b1;
    check(in_sync == 1'b0, "R8 signal lost", in_sync, 0);
    push_comma(0); push_sym(FILL); push_sym(FILL);
    check(in_sync == 1'b0, "R8 count cleared", in_sync, 0);

    // R9: reset in the middle of a synced run
    sync_at(1);
    rst_n = 1'b0;
    #1;
    check(in_sync == 1'b0, "R9 mid-run reset", in_sync, 0);
    check(aligned_word == 10'd0, "R9 word cleared", aligned_word, 0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule